// File: doc/BRIEF.md
# Audio Serial Receiver (Stereo, LSB-Justified)

This block turns a two-channel serial audio stream into parallel samples. A serial data line carries left and right words one after the other. A word-select line tells the two channels apart, and a bit clock times the bits. The receiver can be the timing master: it then makes the bit clock from the system clock with a programmable divider and makes word select from a programmable frame length. It can also be a slave, following a bit clock and word select that another device drives. In slave mode the three pins cross into the system clock domain through two-flop synchronizers, and the receiver detects edges on the synchronized copies.

Framing is LSB-justified. The last bit before a word-select transition is the least significant bit of the word, so the receiver keeps only the final N bits of each half-frame and discards any leading filler bits. The word length N is 16, 18, 20 or 24 bits. A frame may last up to 128 bit clocks.

Each finished word leaves as a right-aligned parallel value with a channel tag and a one-cycle valid strobe, ready to write into a per-channel FIFO. Each channel has a full input. A word that finishes while its channel reports full is dropped, and that channel's sticky overrun flag is set.

Top module: `audio_serial_rx`

## Requirements
- R1: While rstN is low, sampleValid, sampleData, leftOverrun, rightOverrun, bclkOut and wsOut are all 0.
- R2: In master mode (masterMode=1), bclkOut starts low after reset and toggles every clkDiv+1 clk cycles. The smallest allowed clkDiv is 2.
- R3: In master mode, wsOut starts low after reset and changes only on falling edges of bclkOut. Each level lasts exactly frameBits/2 rising edges of bclkOut.
- R4: In slave mode, bclkIn, wsIn and sdIn pass through two-flop synchronizers. A word finished by a rising bclkIn edge has its sampleValid pulse on the third clk rising edge after that edge reaches the pins.
- R5: In master mode, a finished word's one-cycle sampleValid pulse starts on the same clk edge on which bclkOut rises for the first bit of the next half-frame.
- R6: Serial data is captured on rising bit-clock edges, most significant bit first. wordLenSel sets N: code 0 gives 16, code 1 gives 18, code 2 gives 20 and code 3 gives 24 bits. The delivered word is the last N bits before the word-select transition, right-aligned in sampleData, with the bits above N at zero. Earlier bits of the half-frame are discarded.
- R7: A word received while word select is low is tagged left (sampleRight=0). A word received while it is high is tagged right (sampleRight=1).
- R8: The half-frame in progress when reset is released is never delivered. The first delivered word belongs to the first half-frame that began at an observed word-select transition.
- R9: If a word finishes while its channel's full input (leftFull or rightFull) is high in the cycle before the output edge, the word is dropped: no sampleValid is given. That channel's overrun flag rises on the edge where the pulse would have appeared. The other channel is not affected.
- R10: Once set, an overrun flag stays high until reset.
- R11: In slave mode, bclkOut and wsOut stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1: generate bit clock and word select; 0: follow the pins |
| wordLenSel | input | 2 | Word length code (0:16, 1:18, 2:20, 3:24) |
| frameBits | input | 8 | Bit clocks per word-select period (even, 2N to 128) |
| clkDiv | input | 8 | Master bit-clock half period minus one, in clk cycles |
| bclkIn | input | 1 | External bit clock (slave mode) |
| wsIn | input | 1 | External word select (slave mode) |
| sdIn | input | 1 | Serial data |
| leftFull | input | 1 | Downstream left FIFO is full |
| rightFull | input | 1 | Downstream right FIFO is full |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| wsOut | output | 1 | Generated word select (master mode) |
| sampleData | output | 24 | Received word, right-aligned |
| sampleRight | output | 1 | Channel tag: 0 left, 1 right |
| sampleValid | output | 1 | One-cycle strobe for sampleData and sampleRight |
| leftOverrun | output | 1 | Sticky: a left word was dropped |
| rightOverrun | output | 1 | Sticky: a right word was dropped |

## Verification
Two functions can meet in one cycle: a word finishing and the full input of a channel being high. The full input may belong to the finishing word's own channel or to the other one. The bench drives the two full inputs with windows of different lengths that do not line up with the frame, so over a run words finish under the own channel's full, under the other channel's full, and under neither. A behavioural model predicts, cycle by cycle, whether each word appears or is dropped, and which overrun flag rises. It judges this from the full value on the wire in the cycle before the output edge, and it checks that a full input on one channel never blocks or flags the other.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

  // Word length codes, as applied on wordLenSel
  typedef enum logic [1:0] {
    WL16 = 2'd0,
    WL18 = 2'd1,
    WL20 = 2'd2,
    WL24 = 2'd3
  } wordLen_e;

  // One captured bit as seen by the datapath
  typedef struct packed {
    logic bitTick;   // rising bit-clock edge in this cycle
    logic wsLevel;   // word select at that edge
    logic sdBit;     // serial data at that edge
  } bitStrobe_t;

  function automatic int unsigned lenBits(wordLen_e sel);
    case (sel)
      WL16:    return 16;
      WL18:    return 18;
      WL20:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/i2srx_ctrl.sv
module i2srx_ctrl
  import i2srx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterMode,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               bclkIn,
  input  logic               wsIn,
  input  logic               sdIn,
  output logic               bclkOut,
  output logic               wsOut,
  output bitStrobe_t         strobe
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  // ---------------- slave path: pin synchronizers ----------------
  logic [SYNC_STAGES-1:0][2:0] syncPipe;
  logic [2:0]                  syncOut;
  logic                        bclkSync, wsSync, sdSync, bclkPrev, slaveRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      bclkPrev <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], {sdIn, wsIn, bclkIn}};
      bclkPrev <= bclkSync;
    end
  end

  assign syncOut   = syncPipe[LAST_STAGE];
  assign bclkSync  = syncOut[0];
  assign wsSync    = syncOut[1];
  assign sdSync    = syncOut[2];
  assign slaveRise = bclkSync & ~bclkPrev;

  // ---------------- master path: clock and frame generation ----------------
  logic [DIV_W-1:0]   divCnt;
  logic [FRAME_W-1:0] bitCnt;
  logic [FRAME_W-1:0] halfLen;
  logic               bclkGen, wsGen, divWrap, masterRise;

  assign halfLen    = frameBits >> 1;
  assign divWrap    = (divCnt == clkDiv);
  assign masterRise = masterMode & divWrap & ~bclkGen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitCnt  <= '0;
      bclkGen <= 1'b0;
      wsGen   <= 1'b0;
    end else if (!masterMode) begin
      divCnt  <= '0;
      bitCnt  <= '0;
      bclkGen <= 1'b0;
      wsGen   <= 1'b0;
    end else if (divWrap) begin
      divCnt  <= '0;
      bclkGen <= ~bclkGen;
      if (bclkGen) begin
        // falling edge: advance the bit position, flip word select at the half
        if (bitCnt == halfLen - FRAME_W'(1)) begin
          bitCnt <= '0;
          wsGen  <= ~wsGen;
        end else begin
          bitCnt <= bitCnt + FRAME_W'(1);
        end
      end
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign bclkOut = bclkGen;
  assign wsOut   = wsGen;

  // ---------------- strobe to the datapath ----------------
  always_comb begin
    strobe.bitTick = masterMode ? masterRise : slaveRise;
    strobe.wsLevel = masterMode ? wsGen : wsSync;
    strobe.sdBit   = sdSync;
  end

  // R3
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && !$stable(wsOut) |-> $fell(bclkOut));

  // R2
  bclk_min_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && $rose(bclkOut) |=> $stable(bclkOut));

  // R11
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode && $past(!masterMode) |-> !bclkOut && !wsOut);

endmodule

// File: rtl/i2srx_datapath.sv
module i2srx_datapath
  import i2srx_pkg::*;
#(
  parameter int MAX_WORD = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  bitStrobe_t          strobe,
  input  logic [1:0]          wordLenSel,
  input  logic                leftFull,
  input  logic                rightFull,
  output logic [MAX_WORD-1:0] sampleData,
  output logic                sampleRight,
  output logic                sampleValid,
  output logic                leftOverrun,
  output logic                rightOverrun
);

  logic [MAX_WORD-1:0] shiftReg;
  logic [MAX_WORD-1:0] wordMask;
  wordLen_e            lenSel;
  logic                wsLast, haveWs, armed;
  logic                halfDone, emit, chanFull;

  assign lenSel = wordLen_e'(wordLenSel);

  always_comb begin
    for (int unsigned i = 0; i < MAX_WORD; i++) begin
      wordMask[i] = (i < lenBits(lenSel));
    end
  end

  // A word-select change seen at a bit edge closes the previous half-frame
  assign halfDone = strobe.bitTick & haveWs & (strobe.wsLevel != wsLast);
  assign emit     = halfDone & armed;
  assign chanFull = wsLast ? rightFull : leftFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wsLast   <= 1'b0;
      haveWs   <= 1'b0;
      armed    <= 1'b0;
    end else if (strobe.bitTick) begin
      shiftReg <= {shiftReg[MAX_WORD-2:0], strobe.sdBit};
      wsLast   <= strobe.wsLevel;
      haveWs   <= 1'b1;
      if (halfDone) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleData   <= '0;
      sampleRight  <= 1'b0;
      sampleValid  <= 1'b0;
      leftOverrun  <= 1'b0;
      rightOverrun <= 1'b0;
    end else begin
      sampleValid <= emit & ~chanFull;
      if (emit & ~chanFull) begin
        sampleData  <= shiftReg & wordMask;
        sampleRight <= wsLast;
      end
      if (emit & chanFull & ~wsLast) leftOverrun  <= 1'b1;
      if (emit & chanFull &  wsLast) rightOverrun <= 1'b1;
    end
  end

  // R9
  no_left_write_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !sampleRight |-> !$past(leftFull));

  // R9
  no_right_write_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && sampleRight |-> !$past(rightFull));

  // R10
  left_overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftOverrun |=> leftOverrun);

  // R10
  right_overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rightOverrun |=> rightOverrun);

  // R6
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleData & ~wordMask) == '0);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import i2srx_pkg::*;
#(
  parameter int MAX_WORD    = 24,
  parameter int DIV_W       = 8,
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterMode,
  input  logic [1:0]          wordLenSel,
  input  logic [FRAME_W-1:0]  frameBits,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic                bclkIn,
  input  logic                wsIn,
  input  logic                sdIn,
  input  logic                leftFull,
  input  logic                rightFull,
  output logic                bclkOut,
  output logic                wsOut,
  output logic [MAX_WORD-1:0] sampleData,
  output logic                sampleRight,
  output logic                sampleValid,
  output logic                leftOverrun,
  output logic                rightOverrun
);

  bitStrobe_t bitStrobe;

  i2srx_ctrl #(
    .DIV_W      (DIV_W),
    .FRAME_W    (FRAME_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterMode(masterMode),
    .clkDiv    (clkDiv),
    .frameBits (frameBits),
    .bclkIn    (bclkIn),
    .wsIn      (wsIn),
    .sdIn      (sdIn),
    .bclkOut   (bclkOut),
    .wsOut     (wsOut),
    .strobe    (bitStrobe)
  );

  i2srx_datapath #(
    .MAX_WORD(MAX_WORD)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (bitStrobe),
    .wordLenSel  (wordLenSel),
    .leftFull    (leftFull),
    .rightFull   (rightFull),
    .sampleData  (sampleData),
    .sampleRight (sampleRight),
    .sampleValid (sampleValid),
    .leftOverrun (leftOverrun),
    .rightOverrun(rightOverrun)
  );

endmodule

// File: tb/audio_serial_rx_bench.sv
`timescale 1ns/1ps
module audio_serial_rx_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        masterMode = 1'b0;
  logic [1:0]  wordLenSel = 2'd0;
  logic [7:0]  frameBits = 8'd32;
  logic [7:0]  clkDiv = 8'd2;
  logic        bclkIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic        leftFull = 1'b0, rightFull = 1'b0;
  logic        bclkOut, wsOut, sampleRight, sampleValid, leftOverrun, rightOverrun;
  logic [23:0] sampleData;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .wordLenSel(wordLenSel),
    .frameBits(frameBits), .clkDiv(clkDiv), .bclkIn(bclkIn), .wsIn(wsIn),
    .sdIn(sdIn), .leftFull(leftFull), .rightFull(rightFull), .bclkOut(bclkOut),
    .wsOut(wsOut), .sampleData(sampleData), .sampleRight(sampleRight),
    .sampleValid(sampleValid), .leftOverrun(leftOverrun), .rightOverrun(rightOverrun)
  );

  int checks = 0;
  int errors = 0;
  int cycle  = 0;

  // configuration of the running phase
  bit running = 0;
  bit isMaster, fullOn;
  int nBits, half, clkDivI, hp;

  // transmitter state
  int          pos, ph;
  logic [23:0] curWord, prevWord;
  logic        txWs;

  // reference model state
  typedef struct {
    int          due;
    logic [23:0] word;
    bit          ch;
  } ev_t;
  ev_t  evq[$];
  bit   haveWs, armed, lastWs, bclkSeen, edgeSeen;
  bit   expOvr[2];
  int   lastEdge, riseCnt, delivered;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (cycle %0d)", what, act, exp, cycle);
    end
  endtask

  function automatic logic [23:0] newWord();
    logic [23:0] w;
    w = 24'($urandom());
    for (int i = 0; i < 24; i++) if (i >= nBits) w[i] = 1'b0;
    return w;
  endfunction

  // Bit carried at a position of the half-frame: filler first, word at the end
  function automatic logic bitFor(input int p);
    if (p >= half - nBits) return curWord[half - 1 - p];
    return 1'($urandom());
  endfunction

  task automatic modelRise(input bit ws, input int lat);
    if (!haveWs) begin
      haveWs = 1;
    end else if (ws != lastWs) begin
      if (armed) evq.push_back('{due: cycle + lat, word: prevWord, ch: lastWs});
      armed = 1;
    end
    lastWs = ws;
  endtask

  task automatic compareOutputs();
    if (evq.size() > 0 && evq[0].due == cycle) begin
      ev_t e;
      bit  f;
      e = evq.pop_front();
      f = e.ch ? rightFull : leftFull;
      if (f) begin
        expOvr[e.ch] = 1;
        check(sampleValid == 1'b0, "R9 word written although channel full", sampleValid, 0);
      end else begin
        check(sampleValid == 1'b1, isMaster ? "R5 valid timing (master)" : "R4 valid timing (slave)",
              sampleValid, 1);
        if (sampleValid) begin
          delivered++;
          check(sampleData == e.word, "R6 received word", sampleData, e.word);
          check(sampleRight == e.ch, "R7 channel tag", sampleRight, e.ch);
        end
      end
    end else begin
      check(sampleValid == 1'b0, "R8 unexpected valid", sampleValid, 0);
    end
    check(leftOverrun == expOvr[0], expOvr[0] ? "R10 left overrun lost" : "R9 left overrun",
          leftOverrun, expOvr[0]);
    check(rightOverrun == expOvr[1], expOvr[1] ? "R10 right overrun lost" : "R9 right overrun",
          rightOverrun, expOvr[1]);
  endtask

  always @(negedge clk) begin : model
    bit rise, fall;
    cycle++;
    if (running) begin
      rise = 0;
      fall = 0;
      if (isMaster) begin
        rise = bclkOut && !bclkSeen;
        fall = !bclkOut && bclkSeen;
        if (rise || fall) begin
          if (edgeSeen) check(cycle - lastEdge == clkDivI + 1, "R2 bit clock half period",
                              cycle - lastEdge, clkDivI + 1);
          lastEdge = cycle;
          edgeSeen = 1;
        end
        bclkSeen = bclkOut;
        if (rise) begin
          riseCnt++;
          modelRise(wsOut, 0);
        end
      end else begin
        check(bclkOut == 1'b0 && wsOut == 1'b0, "R11 outputs quiet in slave mode",
              {bclkOut, wsOut}, 0);
      end

      compareOutputs();

      leftFull  = fullOn && ((cycle / 53) % 3 == 0);
      rightFull = fullOn && ((cycle / 71) % 4 == 1);

      if (isMaster) begin
        if (fall) begin
          if (wsOut != txWs) begin
            check(riseCnt == half, "R3 rising edges per word-select level", riseCnt, half);
            riseCnt  = 0;
            txWs     = wsOut;
            pos      = 0;
            prevWord = curWord;
            curWord  = newWord();
          end else begin
            pos++;
          end
          sdIn = bitFor(pos);
        end
      end else begin
        ph++;
        if (ph == hp) begin
          bclkIn = 1'b1;
        end else if (ph == 2 * hp) begin
          ph     = 0;
          bclkIn = 1'b0;
          pos++;
          if (pos == half) begin
            pos      = 0;
            txWs     = ~txWs;
            wsIn     = txWs;
            prevWord = curWord;
            curWord  = newWord();
          end
          sdIn = bitFor(pos);
        end
        if (bclkIn && !bclkSeen) modelRise(wsIn, 3);
        bclkSeen = bclkIn;
      end
    end
  end

  task automatic runPhase(input bit m, input int code, input int fb, input int dv,
                          input int hpv, input bit fo, input int ncyc);
    running = 0;
    @(posedge clk); #1;
    rstN       = 1'b0;
    masterMode = m;
    wordLenSel = 2'(code);
    frameBits  = 8'(fb);
    clkDiv     = 8'(dv);
    bclkIn = 1'b0; wsIn = 1'b0; sdIn = 1'b0;
    leftFull = 1'b0; rightFull = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(sampleValid == 1'b0 && sampleData == 24'd0, "R1 reset outputs", {sampleValid, sampleData}, 0);
    check(leftOverrun == 1'b0 && rightOverrun == 1'b0, "R1 reset overrun flags",
          {leftOverrun, rightOverrun}, 0);
    check(bclkOut == 1'b0 && wsOut == 1'b0, "R1 reset clocks", {bclkOut, wsOut}, 0);
    isMaster = m; fullOn = fo;
    nBits = (code == 0) ? 16 : (code == 1) ? 18 : (code == 2) ? 20 : 24;
    half = fb / 2; clkDivI = dv; hp = hpv;
    pos = 0; ph = 0; txWs = 0;
    curWord = newWord(); prevWord = 24'd0;
    sdIn = bitFor(0);
    evq.delete();
    haveWs = 0; armed = 0; lastWs = 0; bclkSeen = 0; edgeSeen = 0;
    expOvr[0] = 0; expOvr[1] = 0;
    lastEdge = 0; riseCnt = 0; delivered = 0;
    rstN    = 1'b1;
    running = 1;
    repeat (ncyc) @(posedge clk);
    #1;
    running = 0;
    check(delivered >= 4, "R6 words delivered in phase", delivered, 4);
  endtask

  initial begin
    runPhase(1, 0, 32, 2, 3, 0, 2500);   // master, 16-bit, no filler
    runPhase(1, 3, 64, 3, 3, 1, 3000);   // master, 24-bit, filler, full windows
    runPhase(0, 1, 48, 2, 3, 1, 3500);   // slave, 18-bit, full windows
    runPhase(0, 2, 128, 2, 3, 0, 5500);  // slave, 20-bit, longest frame
    runPhase(1, 1, 36, 2, 3, 1, 2500);   // master, 18-bit, half equals word
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycle);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule